// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block holds the per-channel control and status state for a four-channel DMA controller. A CPU reaches one 8-bit register per channel through a channel select with read and write strobes. Each channel's transfer engine reports completion with a terminal-count pulse and raises a hardware request line. The block answers each channel with three signals: an enable level, a start pulse when a request is accepted, and an abort pulse when the transfer must be forcibly stopped. A global non-maskable interrupt input aborts every channel.

The behaviour turns on two bits: a completion flag that is cleared when the register is read, and a keep-enabled mode bit. With the mode bit set, the channel stays enabled through terminal count, and hardware requests keep flowing without a status read. A software trigger, however, still waits until the flag has been read. With the mode bit clear, terminal count disables the channel. Software must then enable the channel again and read the flag before any further request is accepted. Every interface here is a plain control strobe or level, so none of them uses a valid/ready handshake and none of them can be back-pressured.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset, every channel register is 00h, and the xfer_en, start_pulse and abort_pulse outputs are all 0.
- R2: A read strobe loads rd_data on the next clock edge with the selected channel's word: bit 7 = done flag, bit 3 = keep mode, bit 0 = enable, and all other bits 0. Without a read strobe, rd_data holds its value.
- R3: A terminal-count pulse sets the channel's done flag. A read of that channel clears the flag. When a read and a terminal count fall in the same cycle, the flag ends up set.
- R4: At terminal count with keep mode = 1, the enable bit is not cleared.
- R5: At terminal count with keep mode = 0, the enable bit is cleared.
- R6: Writing bit 1 = 1 makes a start pulse in the next cycle, but only if the channel's enable was 1 and its done flag was 0 before the write.
- R7: A hardware request makes a start pulse in the next cycle when enable = 1 and either keep mode = 1 or the done flag = 0.
- R8: Writing bit 2 = 1 makes an abort pulse in the next cycle, clears the enable bit, and suppresses any start pulse for that cycle.
- R9: The nmi input makes an abort pulse on every channel in the next cycle, clears every enable bit, and suppresses start pulses.
- R10: A write changes only the selected channel's keep and enable bits from bits 3 and 0. The value written to bit 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 2 | Channel select for read and write |
| rd_stb | input | 1 | Register read strobe |
| wr_stb | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| tc_pulse | input | 4 | Terminal-count pulse per channel |
| hw_req | input | 4 | Hardware request per channel |
| nmi | input | 1 | Non-maskable abort to all channels |
| xfer_en | output | 4 | Enable level per channel |
| start_pulse | output | 4 | Accepted-request pulse per channel |
| abort_pulse | output | 4 | Forced-termination pulse per channel |

## Verification
Every result is due exactly one clock after the stimulus that causes it. This holds for the enable level, the start and abort pulses, and the read word, because each comes straight from a register updated at that edge. The bench drives inputs just after a falling edge and lets one rising edge pass. It compares all outputs at the next falling edge against a reference model that applies the same edge's update to the state held before that edge. Directed sequences cover the same-cycle read-and-terminal-count case, the mode-dependent request rules and aborts. Seeded random traffic then mixes all inputs.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int REG_W    = 8;
  localparam int DONE_BIT = 7;
  localparam int KEEP_BIT = 3;
  localparam int KILL_BIT = 2;
  localparam int TRIG_BIT = 1;
  localparam int ENA_BIT  = 0;

  typedef struct packed {
    logic done;
    logic keep;
    logic ena;
  } ch_state_t;
endpackage

// File: rtl/dma_chan_reg.sv
module dma_chan_reg
  import dma_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_hit,
  input  logic      rd_hit,
  input  logic      w_keep,
  input  logic      w_kill,
  input  logic      w_trig,
  input  logic      w_ena,
  input  logic      tc,
  input  logic      nmi,
  output ch_state_t state,
  output logic      abort_req,
  output logic      trig_req
);
  ch_state_t st_q, st_d;

  assign abort_req = (wr_hit & w_kill) | nmi;
  assign trig_req  = wr_hit & w_trig;

  always_comb begin
    st_d = st_q;
    if (wr_hit) begin
      st_d.keep = w_keep;
      st_d.ena  = w_ena;
    end
    if (tc && !st_q.keep) st_d.ena = 1'b0;
    if (abort_req)        st_d.ena = 1'b0;
    if (tc)               st_d.done = 1'b1;
    else if (rd_hit)      st_d.done = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign state = st_q;

  // R3
  tc_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> state.done);
  // R3
  read_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !tc) |=> !state.done);
  // R4
  keep_holds_ena_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && state.keep && state.ena && !wr_hit && !nmi) |=> state.ena);
  // R5
  tc_drops_ena_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !state.keep) |=> !state.ena);
  // R9
  nmi_drops_ena_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |=> !state.ena);
endmodule

// File: rtl/dma_start_gate.sv
module dma_start_gate
  import dma_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ch_state_t state,
  input  logic      abort_req,
  input  logic      trig_req,
  input  logic      hw_req,
  output logic      start_o,
  output logic      abort_o
);
  logic sw_ok, hw_ok;

  assign sw_ok = trig_req & state.ena & ~state.done;
  assign hw_ok = hw_req & state.ena & (state.keep | ~state.done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_o <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      start_o <= (sw_ok | hw_ok) & ~abort_req;
      abort_o <= abort_req;
    end
  end

  // R8
  abort_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> (abort_o && !start_o));
  // R6
  trig_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_req && !hw_req && (!state.ena || state.done)) |=> !start_o);
  // R7
  hw_keep_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_req && state.ena && state.keep && !abort_req) |=> start_o);
endmodule

// File: rtl/dma_rd_mux.sv
module dma_rd_mux
  import dma_ctl_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_stb,
  input  logic [SEL_W-1:0]        sel,
  input  ch_state_t [NUM_CH-1:0]  states,
  output logic [REG_W-1:0]        rd_data
);
  logic [REG_W-1:0] word;

  always_comb begin
    word = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel == SEL_W'(i)) begin
        word[DONE_BIT] = states[i].done;
        word[KEEP_BIT] = states[i].keep;
        word[ENA_BIT]  = states[i].ena;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_stb) rd_data <= word;
  end

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_ctl_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic [NUM_CH-1:0] tc_pulse,
  input  logic [NUM_CH-1:0] hw_req,
  input  logic              nmi,
  output logic [NUM_CH-1:0] xfer_en,
  output logic [NUM_CH-1:0] start_pulse,
  output logic [NUM_CH-1:0] abort_pulse
);
  ch_state_t [NUM_CH-1:0] states;
  logic unused_wbits;

  assign unused_wbits = ^{wr_data[DONE_BIT], wr_data[6:4]};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit_w, hit_r, abort_c, trig_c;
    assign hit_w = wr_stb & (sel == SEL_W'(c));
    assign hit_r = rd_stb & (sel == SEL_W'(c));

    dma_chan_reg u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (hit_w),
      .rd_hit    (hit_r),
      .w_keep    (wr_data[KEEP_BIT]),
      .w_kill    (wr_data[KILL_BIT]),
      .w_trig    (wr_data[TRIG_BIT]),
      .w_ena     (wr_data[ENA_BIT]),
      .tc        (tc_pulse[c]),
      .nmi       (nmi),
      .state     (states[c]),
      .abort_req (abort_c),
      .trig_req  (trig_c)
    );

    dma_start_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .state     (states[c]),
      .abort_req (abort_c),
      .trig_req  (trig_c),
      .hw_req    (hw_req[c]),
      .start_o   (start_pulse[c]),
      .abort_o   (abort_pulse[c])
    );

    assign xfer_en[c] = states[c].ena;
  end

  dma_rd_mux #(.NUM_CH(NUM_CH)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_stb  (rd_stb),
    .sel     (sel),
    .states  (states),
    .rd_data (rd_data)
  );

  // R10
  write_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !nmi && (tc_pulse == '0) && (sel != '0) && !xfer_en[0]) |=> !xfer_en[0]);
endmodule

// File: tb/dma_chan_ctl_test.sv
`timescale 1ns/1ps
module dma_chan_ctl_test;
  localparam int CLK_NS = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = '0;
  logic       rd_stb = 1'b0, wr_stb = 1'b0, nmi = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [3:0] tc_pulse = '0, hw_req = '0;
  logic [3:0] xfer_en, start_pulse, abort_pulse;

  int tests = 0, fails = 0;
  bit done_run = 0;

  logic [3:0] m_en = '0, m_keep = '0, m_done = '0;
  logic [7:0] m_rd = '0;
  logic [3:0] e_start, e_abort;

  always #(CLK_NS/2) clk = ~clk;

  dma_chan_ctl uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_data(rd_data), .tc_pulse(tc_pulse), .hw_req(hw_req),
    .nmi(nmi), .xfer_en(xfer_en), .start_pulse(start_pulse), .abort_pulse(abort_pulse)
  );

  function automatic logic [7:0] word_of(int c);
    return {m_done[c], 3'b000, m_keep[c], 2'b00, m_en[c]};
  endfunction

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic [1:0] s, logic r, logic w, logic [7:0] d,
                      logic [3:0] t, logic [3:0] h, logic n);
    logic [3:0] n_en, n_keep, n_done;
    sel = s; rd_stb = r; wr_stb = w; wr_data = d; tc_pulse = t; hw_req = h; nmi = n;
    if (r) m_rd = word_of(s);
    for (int c = 0; c < 4; c++) begin
      logic wh, rh, ab;
      wh = w && (s == 2'(c));
      rh = r && (s == 2'(c));
      ab = (wh && d[2]) || n;
      e_abort[c] = ab;
      e_start[c] = !ab && m_en[c] &&
                   ((wh && d[1] && !m_done[c]) || (h[c] && (m_keep[c] || !m_done[c])));
      n_keep[c] = wh ? d[3] : m_keep[c];
      n_en[c]   = wh ? d[0] : m_en[c];
      if (t[c] && !m_keep[c]) n_en[c] = 1'b0;
      if (ab) n_en[c] = 1'b0;
      n_done[c] = t[c] ? 1'b1 : (rh ? 1'b0 : m_done[c]);
    end
    m_en = n_en; m_keep = n_keep; m_done = n_done;
    @(posedge clk);
    @(negedge clk);
    check(tag, "xfer_en", {4'b0, xfer_en}, {4'b0, m_en});
    check(tag, "start_pulse", {4'b0, start_pulse}, {4'b0, e_start});
    check(tag, "abort_pulse", {4'b0, abort_pulse}, {4'b0, e_abort});
    check(tag, "rd_data", rd_data, m_rd);
  endtask

  task automatic idle(string tag);
    step(tag, 2'd0, 1'b0, 1'b0, 8'h00, 4'h0, 4'h0, 1'b0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done_run) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1", "xfer_en", {4'b0, xfer_en}, 8'h00);
    check("R1", "start_pulse", {4'b0, start_pulse}, 8'h00);
    check("R1", "abort_pulse", {4'b0, abort_pulse}, 8'h00);
    for (int c = 0; c < 4; c++) step("R1", 2'(c), 1'b1, 1'b0, 8'h00, 4'h0, 4'h0, 1'b0);
    // R10: write ch1 with bit7 set, others unaffected
    step("R10", 2'd1, 1'b0, 1'b1, 8'h89, 4'h0, 4'h0, 1'b0);
    step("R10", 2'd1, 1'b1, 1'b0, 8'h00, 4'h0, 4'h0, 1'b0);
    check("R10", "ch1 word", rd_data, 8'h09);
    // R6: software trigger accepted
    step("R6", 2'd1, 1'b0, 1'b1, 8'h0B, 4'h0, 4'h0, 1'b0);
    check("R6", "start ch1", {7'b0, start_pulse[1]}, 8'h01);
    // R3/R4: terminal count keeps enable, sets flag
    step("R4", 2'd0, 1'b0, 1'b0, 8'h00, 4'h2, 4'h0, 1'b0);
    check("R4", "en ch1 kept", {7'b0, xfer_en[1]}, 8'h01);
    // R6: trigger blocked while flag set
    step("R6", 2'd1, 1'b0, 1'b1, 8'h0B, 4'h0, 4'h0, 1'b0);
    check("R6", "no start ch1", {7'b0, start_pulse[1]}, 8'h00);
    // R7: hw request accepted with flag set in keep mode
    step("R7", 2'd0, 1'b0, 1'b0, 8'h00, 4'h0, 4'h2, 1'b0);
    check("R7", "hw start ch1", {7'b0, start_pulse[1]}, 8'h01);
    // R3: read and tc together keep the flag
    step("R3", 2'd1, 1'b1, 1'b0, 8'h00, 4'h2, 4'h0, 1'b0);
    check("R3", "read old word", rd_data, 8'h89);
    step("R3", 2'd1, 1'b1, 1'b0, 8'h00, 4'h0, 4'h0, 1'b0);
    check("R3", "flag survived", rd_data, 8'h89);
    step("R3", 2'd1, 1'b1, 1'b0, 8'h00, 4'h0, 4'h0, 1'b0);
    check("R3", "flag cleared", rd_data, 8'h09);
    // R5: mode 0, tc drops enable; hw then blocked
    step("R5", 2'd0, 1'b0, 1'b1, 8'h01, 4'h0, 4'h0, 1'b0);
    step("R5", 2'd0, 1'b0, 1'b0, 8'h00, 4'h1, 4'h0, 1'b0);
    check("R5", "en ch0 dropped", {7'b0, xfer_en[0]}, 8'h00);
    step("R7", 2'd0, 1'b0, 1'b1, 8'h01, 4'h0, 4'h0, 1'b0);
    step("R7", 2'd0, 1'b0, 1'b0, 8'h00, 4'h0, 4'h1, 1'b0);
    check("R7", "hw blocked by flag", {7'b0, start_pulse[0]}, 8'h00);
    // R8: abort write with trigger
    step("R8", 2'd1, 1'b0, 1'b1, 8'h0F, 4'h0, 4'h2, 1'b0);
    check("R8", "abort ch1", {7'b0, abort_pulse[1]}, 8'h01);
    check("R8", "start ch1 suppressed", {7'b0, start_pulse[1]}, 8'h00);
    // R9: nmi aborts all
    step("R9", 2'd2, 1'b0, 1'b1, 8'h09, 4'h0, 4'h0, 1'b0);
    step("R9", 2'd0, 1'b0, 1'b0, 8'h00, 4'h0, 4'hF, 1'b1);
    check("R9", "abort all", {4'b0, abort_pulse}, 8'h0F);
    check("R9", "en all clear", {4'b0, xfer_en}, 8'h00);
    idle("R2");
    // random mix, R2/R7 and the rest checked every cycle
    for (int k = 0; k < 4000; k++) begin
      logic [7:0] d;
      logic [3:0] t, h;
      d = 8'($urandom);
      if ($urandom_range(0, 3) != 0) d[2] = 1'b0;
      t = 4'($urandom) & 4'($urandom) & 4'($urandom);
      h = 4'($urandom);
      step("R7", 2'($urandom), ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
           d, t, h, ($urandom_range(0, 49) == 0));
    end
    done_run = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule